// File: doc/BRIEF.md
# Thread-to-Core Voltage Domain Scheduler

This block decides which thread runs on which core of a multicore cluster in which each core is fixed to one of two supply levels, a fast high-voltage/high-frequency level and a slow low-voltage/low-frequency level. It does not retune any core's supply. Instead it keeps a per-thread estimate of instructions per cycle and moves threads between cores. A thread that retires many instructions per cycle belongs on a fast core. A thread that stalls on memory belongs on a slow core.

Each core reports how many instructions it retired in every cycle, and it pulses a cache-miss line. At the end of every fixed window the scheduler turns each core's retired count into an IPC figure and stores it under the thread that core hosts. On the next cycle it may pick one fast/slow pair of cores whose threads are on the wrong side of a programmable threshold and its hysteresis band. A cache miss on a fast core can also trigger an immediate move. A chosen exchange is presented as a valid/ready request naming the two cores. The thread map is updated when the request is accepted. The context transfer itself is carried out by the cores.

Top module: `thread_vf_sched`

## Requirements
- R1: After reset, core c hosts thread c, every IPC entry is zero, and no swap request is pending.
- R2: A window lasts WINDOW cycles, and the cycle counter starts at the first clock edge after reset. At the window's last edge, each core's retired total A (including that edge's retire input) becomes the IPC of the thread it hosts. The IPC is computed as floor(A*floor(65536/WINDOW)/1024), saturated at 255, which is IPC in Q2.6.
- R3: In interval mode, the evaluation happens at the first edge after a window closes. A resulting request appears at the outputs right after that edge.
- R4: A thread on a fast core is a demotion candidate when ipc+hyst < thr. A thread on a slow core is a promotion candidate when ipc > thr+hyst. Values inside the band cause no move.
- R5: Core c is fast when (c mod CL_SIZE) < CL_SIZE/2, and its cluster is c / CL_SIZE. Every swap pairs one fast demotion core with one slow promotion core. A same-cluster pair is preferred. Within a tier, the lowest fast core index wins, then the lowest slow core index.
- R6: In miss mode, a miss pulse on a fast core makes that core a demotion candidate in that same cycle, whatever its IPC, and its partner is chosen as in R5. Miss pulses on slow cores are ignored.
- R7: A request holds valid and both core numbers steady until ready is high. On acceptance, the two cores exchange threads. The map changes at no other time and always stays a permutation. map_o[c*CW +: CW] is the thread on core c.
- R8: While a request is outstanding, interval evaluations and miss pulses are dropped. Valid falls on the edge that accepts the request.
- R9: mode_i bit 0 enables interval evaluation and bit 1 enables miss triggering. With mode 0, no request is ever raised.
- R10: At most one swap is raised per cycle. When an interval evaluation finds a pair, it takes precedence over a simultaneous miss trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bit 0 interval trigger, bit 1 miss trigger |
| thr_i | input | 8 | IPC threshold, Q2.6 |
| hyst_i | input | HYST_W | Half-width of hysteresis band |
| retire_i | input | N_CORES*RET_W | Instructions retired this cycle, per core |
| miss_i | input | N_CORES | Cache-miss pulse, per core |
| swap_valid_o | output | 1 | Swap request pending |
| swap_ready_i | input | 1 | Cores accept the swap |
| swap_hi_core_o | output | CW | Fast core of the pair |
| swap_lo_core_o | output | CW | Slow core of the pair |
| map_o | output | N_CORES*CW | Thread index hosted by each core |

## Verification
A corrupted IPC entry cannot be read directly. It shows up at the first evaluation after the window closes, as a missing swap or a wrong pair, so it is visible within one window plus one cycle. A damaged thread map is visible on map_o at once. It also skews the next window's IPC bookkeeping, because counts are then filed under the wrong thread. A wrong handshake state shows within a cycle, either as a request that drops before ready or as a second request raised while one is still open.

// File: rtl/vf_sched_pkg.sv
package vf_sched_pkg;
  localparam int IPC_W = 8;

  function automatic logic [63:0] fast_mask(input int n, input int cl);
    logic [63:0] m;
    m = '0;
    for (int c = 0; c < n; c++) m[c] = ((c % cl) < (cl / 2));
    return m;
  endfunction
endpackage

// File: rtl/vf_ipc_track.sv
module vf_ipc_track #(
  parameter int N      = 4,
  parameter int CW     = 2,
  parameter int RW     = 2,
  parameter int WINDOW = 200
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N*RW-1:0]                 retire_i,
  input  logic [N*CW-1:0]                 map_i,
  output logic [N*vf_sched_pkg::IPC_W-1:0] ipc_o,
  output logic                            win_end_o
);
  import vf_sched_pkg::*;
  localparam int MAXR   = (1 << RW) - 1;
  localparam int ACC_W  = $clog2(WINDOW * MAXR + 1);
  localparam int RECIP  = 65536 / WINDOW;
  localparam int PROD_W = ACC_W + 17;
  localparam int WC_W   = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [WC_W-1:0]  wcnt_q;
  logic [IPC_W-1:0] ipc_q  [N];
  logic [IPC_W-1:0] conv   [N];
  logic [ACC_W-1:0] acc_q  [N];
  logic [ACC_W-1:0] acc_nx [N];

  assign win_end_o = (wcnt_q == WC_W'(WINDOW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wcnt_q <= '0;
    else if (win_end_o) wcnt_q <= '0;
    else                wcnt_q <= wcnt_q + 1'b1;
  end

  for (genvar c = 0; c < N; c++) begin : g_core
    logic [PROD_W-1:0] prod, scaled;
    assign acc_nx[c] = acc_q[c] + ACC_W'(retire_i[c*RW +: RW]);
    assign prod      = PROD_W'(acc_nx[c]) * PROD_W'(RECIP);
    assign scaled    = prod >> 10;
    assign conv[c]   = (scaled > PROD_W'(255)) ? {IPC_W{1'b1}} : scaled[IPC_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        acc_q[c] <= '0;
      else if (win_end_o) acc_q[c] <= '0;
      else                acc_q[c] <= acc_nx[c];
    end

    assign ipc_o[c*IPC_W +: IPC_W] = ipc_q[c];
  end

  // samples go to the thread hosted before any same-edge exchange
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < N; t++) ipc_q[t] <= '0;
    end else if (win_end_o) begin
      for (int c = 0; c < N; c++) ipc_q[map_i[c*CW +: CW]] <= conv[c];
    end
  end

  assert_window_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q < WC_W'(WINDOW));
  assert_window_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> (wcnt_q == '0));
endmodule

// File: rtl/vf_pair_pick.sv
module vf_pair_pick #(
  parameter int N  = 4,
  parameter int CL = 2,
  parameter int CW = 2
) (
  input  logic [N-1:0]  dem_i,
  input  logic [N-1:0]  pro_i,
  output logic          found_o,
  output logic [CW-1:0] hi_o,
  output logic [CW-1:0] lo_o
);
  import vf_sched_pkg::*;
  localparam logic [63:0] FAST = fast_mask(N, CL);

  logic          f_in, f_any;
  logic [CW-1:0] h_in, l_in, h_any, l_any;

  always_comb begin
    f_in = 1'b0; f_any = 1'b0;
    h_in = '0; l_in = '0; h_any = '0; l_any = '0;
    for (int h = 0; h < N; h++) begin
      for (int l = 0; l < N; l++) begin
        if (dem_i[h] && pro_i[l] && FAST[h] && !FAST[l]) begin
          if (!f_in && (h / CL == l / CL)) begin
            f_in = 1'b1; h_in = CW'(h); l_in = CW'(l);
          end
          if (!f_any) begin
            f_any = 1'b1; h_any = CW'(h); l_any = CW'(l);
          end
        end
      end
    end
    found_o = f_in | f_any;
    hi_o    = f_in ? h_in : h_any;
    lo_o    = f_in ? l_in : l_any;
  end

  always_comb begin
    if (found_o === 1'b1) begin
      assert_pick_legal_R4: assert (dem_i[hi_o] && pro_i[lo_o]);
      assert_pick_domain_R5: assert (FAST[hi_o] && !FAST[lo_o]);
    end
  end
endmodule

// File: rtl/thread_vf_sched.sv
module thread_vf_sched #(
  parameter int N_CORES = 4,
  parameter int CL_SIZE = 2,
  parameter int WINDOW  = 200,
  parameter int RET_W   = 2,
  parameter int HYST_W  = 4,
  localparam int CW     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            mode_i,
  input  logic [7:0]            thr_i,
  input  logic [HYST_W-1:0]     hyst_i,
  input  logic [N_CORES*RET_W-1:0] retire_i,
  input  logic [N_CORES-1:0]    miss_i,
  output logic                  swap_valid_o,
  input  logic                  swap_ready_i,
  output logic [CW-1:0]         swap_hi_core_o,
  output logic [CW-1:0]         swap_lo_core_o,
  output logic [N_CORES*CW-1:0] map_o
);
  import vf_sched_pkg::*;
  localparam logic [63:0] FAST = fast_mask(N_CORES, CL_SIZE);

  logic [CW-1:0]    map_q [N_CORES];
  logic [IPC_W-1:0] ipc_tab [N_CORES];
  logic [IPC_W-1:0] core_ipc [N_CORES];
  logic [N_CORES*IPC_W-1:0] ipc_flat;
  logic [N_CORES-1:0] dem_int, dem_miss, pro;
  logic win_end, eval_q;
  logic swap_valid_q;
  logic [CW-1:0] swap_hi_q, swap_lo_q;
  logic int_found, miss_found, int_go, miss_go, hs;
  logic [CW-1:0] int_hi, int_lo, miss_hi, miss_lo;

  vf_ipc_track #(.N(N_CORES), .CW(CW), .RW(RET_W), .WINDOW(WINDOW)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_i), .map_i(map_o),
    .ipc_o(ipc_flat), .win_end_o(win_end)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic [8:0] lo_edge, hi_edge;
    assign ipc_tab[c]  = ipc_flat[c*IPC_W +: IPC_W];
    assign core_ipc[c] = ipc_tab[map_q[c]];
    assign lo_edge     = {1'b0, core_ipc[c]} + 9'(hyst_i);
    assign hi_edge     = {1'b0, thr_i} + 9'(hyst_i);
    assign dem_int[c]  = FAST[c] && (lo_edge < {1'b0, thr_i});
    assign pro[c]      = !FAST[c] && ({1'b0, core_ipc[c]} > hi_edge);
    assign dem_miss[c] = FAST[c] && miss_i[c];
    assign map_o[c*CW +: CW] = map_q[c];
  end

  vf_pair_pick #(.N(N_CORES), .CL(CL_SIZE), .CW(CW)) u_pick_int (
    .dem_i(dem_int), .pro_i(pro), .found_o(int_found), .hi_o(int_hi), .lo_o(int_lo)
  );
  vf_pair_pick #(.N(N_CORES), .CL(CL_SIZE), .CW(CW)) u_pick_miss (
    .dem_i(dem_miss), .pro_i(pro), .found_o(miss_found), .hi_o(miss_hi), .lo_o(miss_lo)
  );

  assign hs      = swap_valid_q && swap_ready_i;
  assign int_go  = eval_q && mode_i[0] && !swap_valid_q && int_found;
  assign miss_go = mode_i[1] && !swap_valid_q && !int_go && miss_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eval_q       <= 1'b0;
      swap_valid_q <= 1'b0;
      swap_hi_q    <= '0;
      swap_lo_q    <= '0;
    end else begin
      eval_q <= win_end;
      if (int_go) begin
        swap_valid_q <= 1'b1; swap_hi_q <= int_hi;  swap_lo_q <= int_lo;
      end else if (miss_go) begin
        swap_valid_q <= 1'b1; swap_hi_q <= miss_hi; swap_lo_q <= miss_lo;
      end else if (hs) begin
        swap_valid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CORES; c++) map_q[c] <= CW'(c);
    end else if (hs) begin
      map_q[swap_hi_q] <= map_q[swap_lo_q];
      map_q[swap_lo_q] <= map_q[swap_hi_q];
    end
  end

  assign swap_valid_o   = swap_valid_q;
  assign swap_hi_core_o = swap_hi_q;
  assign swap_lo_core_o = swap_lo_q;

  logic [N_CORES-1:0] seen;
  always_comb begin
    seen = '0;
    for (int c = 0; c < N_CORES; c++) seen[map_q[c]] = 1'b1;
  end

  assert_map_perm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen == '1);
  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_valid_q && !swap_ready_i) |=> (swap_valid_q && $stable(swap_hi_q) && $stable(swap_lo_q)));
  assert_map_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs |=> $stable(map_o));
  assert_req_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> !swap_valid_q);
  assert_req_domain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_valid_q |-> (FAST[swap_hi_q] && !FAST[swap_lo_q]));
  assert_mode_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swap_valid_q) |-> ($past(mode_i) != 2'b00));
endmodule

// File: tb/sim_thread_vf_sched.sv
module sim_thread_vf_sched;
  localparam int N = 4, CL = 2, W = 200, RW = 2, HW = 4, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd1;
  logic [7:0] thr = 8'd64;
  logic [HW-1:0] hyst = 4'd4;
  logic [N*RW-1:0] retire = '0;
  logic [N-1:0] miss = '0;
  logic ready = 1'b0;
  logic valid;
  logic [CW-1:0] hi_core, lo_core;
  logic [N*CW-1:0] map;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_map[N], m_ipc[N], m_acc[N];
  int m_wcnt, m_hi, m_lo;
  bit m_eval, m_valid;

  always #4 clk = ~clk;

  thread_vf_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .thr_i(thr), .hyst_i(hyst),
    .retire_i(retire), .miss_i(miss), .swap_valid_o(valid), .swap_ready_i(ready),
    .swap_hi_core_o(hi_core), .swap_lo_core_o(lo_core), .map_o(map)
  );

  function automatic bit is_fast(int c); return (c % CL) < (CL / 2); endfunction

  function automatic int to_ipc(int a);
    int v = (a * (65536 / W)) / 1024;
    return (v > 255) ? 255 : v;
  endfunction

  // score orders pairs: same cluster first, then fast index, then slow index
  function automatic void pick(input logic [N-1:0] dem, input logic [N-1:0] pro,
                               output bit f, output int h, output int l);
    int best = 1 << 20;
    f = 0; h = 0; l = 0;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        if (dem[a] && pro[b] && is_fast(a) && !is_fast(b)) begin
          int s = ((a / CL) != (b / CL)) * N * N + a * N + b;
          if (s < best) begin best = s; f = 1; h = a; l = b; end
        end
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin m_map[c] = c; m_ipc[c] = 0; m_acc[c] = 0; end
    m_wcnt = 0; m_eval = 0; m_valid = 0; m_hi = 0; m_lo = 0;
  endtask

  task automatic model_advance();
    logic [N-1:0] dem, pro, mdem;
    bit fi, fm, hs, we;
    int hi_i, lo_i, hm, lm, t;
    hs = m_valid && ready;
    we = (m_wcnt == W - 1);
    for (int c = 0; c < N; c++) begin
      int ci = m_ipc[m_map[c]];
      dem[c]  = is_fast(c) && (ci + int'(hyst) < int'(thr));
      pro[c]  = !is_fast(c) && (ci > int'(thr) + int'(hyst));
      mdem[c] = is_fast(c) && miss[c];
    end
    pick(dem, pro, fi, hi_i, lo_i);
    fi = fi && m_eval && mode[0] && !m_valid;
    pick(mdem, pro, fm, hm, lm);
    fm = fm && mode[1] && !m_valid && !fi;
    for (int c = 0; c < N; c++) begin
      int na = m_acc[c] + int'(retire[c*RW +: RW]);
      if (we) m_ipc[m_map[c]] = to_ipc(na);
      m_acc[c] = we ? 0 : na;
    end
    m_eval = we;
    m_wcnt = we ? 0 : m_wcnt + 1;
    if (hs) begin
      t = m_map[m_hi]; m_map[m_hi] = m_map[m_lo]; m_map[m_lo] = t; m_valid = 0;
    end
    if (fi) begin m_valid = 1; m_hi = hi_i; m_lo = lo_i; end
    else if (fm) begin m_valid = 1; m_hi = hm; m_lo = lm; end
  endtask

  task automatic compare_all();
    chk("R3", "swap_valid", int'(valid), int'(m_valid));
    if (m_valid) begin
      chk("R5", "swap_hi_core", int'(hi_core), m_hi);
      chk("R5", "swap_lo_core", int'(lo_core), m_lo);
    end
    for (int c = 0; c < N; c++) chk("R7", "map", int'(map[c*CW +: CW]), m_map[c]);
  endtask

  task automatic step();
    @(posedge clk); #1;
    model_advance();
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_ret(int a, int b, int c, int d);
    retire = {RW'(d), RW'(c), RW'(b), RW'(a)};
  endtask

  task automatic to_window_start();
    while (m_wcnt != 0) step();
  endtask

  task automatic ack();
    ready = 1'b1; step(); ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: identity map, nothing pending
    chk("R1", "valid after reset", int'(valid), 0);
    for (int c = 0; c < N; c++) chk("R1", "identity map", int'(map[c*CW +: CW]), c);

    // R2/R5: first window, IPCs 0,127,63,63 -> intra pair 0/1
    set_ret(0, 2, 1, 1);
    repeat (W) step();
    chk("R3", "no request at window close", int'(valid), 0);
    step();
    chk("R3", "request one cycle after close", int'(valid), 1);
    chk("R5", "intra fast core", int'(hi_core), 0);
    chk("R5", "intra slow core", int'(lo_core), 1);
    set_ret(1, 1, 1, 1);
    repeat (5) step();
    chk("R7", "held valid", int'(valid), 1);
    chk("R7", "held hi", int'(hi_core), 0);
    ack();
    chk("R8", "valid drops on accept", int'(valid), 0);
    chk("R7", "core0 thread", int'(map[0 +: CW]), 1);
    chk("R7", "core1 thread", int'(map[CW +: CW]), 0);
    to_window_start();

    // R5: only cross-cluster pair 0/3
    set_ret(0, 1, 1, 2);
    repeat (W + 1) step();
    chk("R5", "cross valid", int'(valid), 1);
    chk("R5", "cross fast core", int'(hi_core), 0);
    chk("R5", "cross slow core", int'(lo_core), 3);
    set_ret(1, 1, 1, 1);
    ack();
    chk("R7", "core0 after cross", int'(map[0 +: CW]), 3);
    chk("R7", "core3 after cross", int'(map[3*CW +: CW]), 1);
    to_window_start();

    // R4: ipc 63 with thr 64 hyst 1 sits in band
    hyst = 4'd1;
    set_ret(1, 2, 1, 1);
    repeat (W + 1) step();
    chk("R4", "in band no swap", int'(valid), 0);
    hyst = 4'd0; mode = 2'd3;
    to_window_start();
    // R10: interval pair 0/1 beats miss on core 2 in the same cycle
    miss = 4'b0100;
    step();
    miss = '0;
    chk("R10", "one request", int'(valid), 1);
    chk("R10", "interval wins hi", int'(hi_core), 0);
    chk("R2", "ipc 63 vs 127 pair lo", int'(lo_core), 1);
    ack();
    chk("R7", "core1 thread", int'(map[CW +: CW]), 3);

    // R6: miss-driven
    mode = 2'd2; thr = 8'd32; set_ret(1, 1, 1, 1);
    miss = 4'b0100;
    step();
    miss = '0;
    chk("R6", "miss request", int'(valid), 1);
    chk("R6", "miss fast core", int'(hi_core), 2);
    chk("R6", "miss slow core", int'(lo_core), 3);
    miss = 4'b0001;
    step();
    miss = '0;
    chk("R8", "miss dropped while busy", int'(hi_core), 2);
    ack();
    chk("R7", "core2 thread", int'(map[2*CW +: CW]), 1);
    miss = 4'b0010;
    step();
    miss = '0;
    chk("R6", "slow core miss ignored", int'(valid), 0);
    mode = 2'd1; miss = 4'b0001;
    step();
    miss = '0;
    chk("R9", "miss off in interval mode", int'(valid), 0);

    // R9: mode 0 never raises
    mode = 2'd0; thr = 8'd64; hyst = 4'd4; set_ret(0, 2, 0, 2);
    repeat (W + 3) step();
    chk("R9", "mode 0 silent", int'(valid), 0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 400 == 0) begin
        mode = 2'($urandom_range(0, 3));
        thr  = 8'($urandom_range(40, 150));
        hyst = HW'($urandom_range(0, 15));
      end
      retire = N*RW'($urandom);
      miss   = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
      ready  = ($urandom_range(0, 2) == 0);
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule